// File: doc/BRIEF.md
# Two-Phase LMS Sequencing Controller

This block is the control unit of a serial adaptive-filter engine. The engine computes each filter output one tap at a time with a single shared multiplier, forms an error term, then revisits every tap to adjust its coefficient. The controller produces every strobe that engine needs: it loads a new input and reference sample, rotates the sample and coefficient stacks, starts the multiplier, accumulates products, subtracts to form the error, latches the error, switches the multiplier operands over to the update path and writes each adjusted coefficient back.

Two saturating counters live inside the block. The cycle counter measures how long a multiply has been running. The tap counter records how many taps have been handled in the current phase. Each wait state examines the flag pair {cycle done, tap done} and chooses its outputs from it. An iteration has two phases. The filter phase handles eight taps and ends with the error latch. The update phase handles eight coefficient write-backs. Each phase is preceded by an idle cycle that puts the first multiplier start on an even cycle. A `restart` input returns the sequence to its start state from any point.

There is no streaming data at this block's edge. Every pin is a plain level or strobe with no handshake.

Top module: `lms_seq_ctrl`

## Requirements
- R1: The first cycle after reset is the start state. In it exactly `ld_sample`, `mul_load`, `tap_clr` and `cyc_clr` are high. The next cycle asserts exactly `rot_x`, `rot_w` and `tap_ph_a`.
- R2: In any cycle where `restart` is high, only `clr_all` and `clr_acc` are high, even if a wait would complete in that cycle. The first cycle after `restart` falls is the start state. A full iteration then follows.
- R3: The cycle counter (limit MUL_CYCLES=8) steps every cycle. The tap counter (limit TAPS=8) steps on `tap_ph_b`. Both saturate at their limit and are cleared by their own clear strobe or by `clr_all`. Each flag is high while its count equals the limit. As a result, the first filter wait completes 9 cycles after the start state, and the seventh filter tap does not end the loop.
- R4: A filter wait keeps every strobe low until the cycle flag is set. On flags {cycle,tap}=10 it asserts exactly `acc_en`, `mul_load` and `cyc_clr`. On flags 11 it asserts exactly `acc_en`.
- R5: After the eighth product is accumulated, `mul_mode` and `subtract` are high for two consecutive cycles, 73 and 74. `err_en` is high in the second of those cycles only.
- R6: Cycle 75 is an idle cycle with every strobe low. In cycle 76 exactly `wgt_sel`, `mul_load`, `tap_clr`, `cyc_clr` and `clr_acc` are high.
- R7: `upd_sel` is high in every update-phase cycle except the loop-advance cycles, 65 cycles in all. Each update wait completion asserts `st_weight`. Completions with flags 10 also assert `wgt_sel`, `mul_load` and `cyc_clr`; the first of these falls at cycle 85. The final completion, with flags 11, asserts exactly `upd_sel`, `st_weight` and `rot_x` at cycle 148.
- R8: After the eighth write-back comes an idle cycle (149). Cycle 150 asserts exactly `clr_all` and `clr_acc`. Cycle 151 is the start state again, so one iteration takes 151 cycles.
- R9: Per iteration, the strobes are high for the following numbers of cycles: `ld_sample` 1, `st_weight` 8, `rot_x` 17, `rot_w` 16, `upd_sel` 65, `wgt_sel` 8, `mul_mode` 18, `mul_load` 16, `tap_clr` 2, `cyc_clr` 16, `tap_ph_a` 16, `tap_ph_b` 16, `subtract` 2, `acc_en` 16, `err_en` 1, `clr_all` 1, `clr_acc` 9.
- R10: `tap_ph_a` and `tap_ph_b` are never high together. Every `tap_ph_b` cycle immediately follows a `tap_ph_a` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Return to the start state from any state |
| ld_sample | output | 1 | Capture new input and reference samples |
| st_weight | output | 1 | Write the adjusted coefficient back |
| rot_x | output | 1 | Rotate the sample stack |
| rot_w | output | 1 | Rotate the coefficient stack |
| upd_sel | output | 1 | Multiplier operand select: update path |
| wgt_sel | output | 1 | Coefficient write-path select |
| mul_mode | output | 1 | Multiplier operand mode for error/update products |
| mul_load | output | 1 | Load multiplier operands and start |
| tap_clr | output | 1 | Clear the tap counter |
| cyc_clr | output | 1 | Clear the cycle counter |
| tap_ph_a | output | 1 | First phase of a tap step |
| tap_ph_b | output | 1 | Second phase of a tap step (advances the tap counter) |
| subtract | output | 1 | Adder in subtract mode |
| acc_en | output | 1 | Accumulate the multiplier product |
| err_en | output | 1 | Latch the error term |
| clr_all | output | 1 | Clear all datapath registers |
| clr_acc | output | 1 | Clear the accumulator |

## Verification
The collision of interest is a `restart` that arrives in the same cycle as a wait completion. Two cases are provoked: `restart` raised at cycle 9, where the first filter product is accumulated and the multiplier reloaded, and `restart` raised at cycle 85, where the first coefficient write-back happens. In both cases the cycle must show only the two clear strobes, with no accumulate, reload or write-back. The next cycle must be the start state, and a complete, exactly timed iteration must follow. That iteration shows that the partly advanced counters were cleared by the restart.

// File: rtl/lms_seq_pkg.sv
package lms_seq_pkg;

  typedef enum logic [3:0] {
    ST_START,
    ST_FETCH,
    ST_TURN,
    ST_ARM,
    ST_FWAIT,
    ST_FNEXT,
    ST_SUBT,
    ST_ELATCH,
    ST_ALIGN_A,
    ST_USTART,
    ST_UACC,
    ST_UARM,
    ST_UWAIT,
    ST_UNEXT,
    ST_ALIGN_B
  } seq_state_e;

  typedef struct packed {
    logic ld_sample;
    logic st_weight;
    logic rot_x;
    logic rot_w;
    logic upd_sel;
    logic wgt_sel;
    logic mul_mode;
    logic mul_load;
    logic tap_clr;
    logic cyc_clr;
    logic tap_ph_a;
    logic tap_ph_b;
    logic subtract;
    logic acc_en;
    logic err_en;
    logic clr_all;
    logic clr_acc;
  } strobe_t;

endpackage

// File: rtl/lms_step_counter.sv
module lms_step_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (en && cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/lms_seq_fsm.sv
module lms_seq_fsm
  import lms_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart,
  input  logic    cyc_done,
  input  logic    tap_done,
  output strobe_t stb
);
  seq_state_e state, nxt;
  logic [1:0] flg;

  assign flg = {cyc_done, tap_done};

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_START;
    else        state <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = state;
    if (restart) begin
      stb.clr_all = 1'b1;
      stb.clr_acc = 1'b1;
      nxt = ST_START;
    end else begin
      case (state)
        ST_START: begin
          stb.ld_sample = 1'b1; stb.mul_load = 1'b1;
          stb.tap_clr = 1'b1;   stb.cyc_clr = 1'b1;
          nxt = ST_FETCH;
        end
        ST_FETCH: begin
          stb.rot_x = 1'b1; stb.rot_w = 1'b1; stb.tap_ph_a = 1'b1;
          nxt = ST_TURN;
        end
        ST_TURN: begin
          stb.tap_ph_b = 1'b1;
          nxt = ST_ARM;
        end
        ST_ARM: nxt = ST_FWAIT;
        ST_FWAIT: begin
          case (flg)
            2'b10: begin
              stb.mul_load = 1'b1; stb.acc_en = 1'b1; stb.cyc_clr = 1'b1;
              nxt = ST_FNEXT;
            end
            2'b11: begin
              stb.acc_en = 1'b1;
              nxt = ST_FNEXT;
            end
            default: nxt = ST_FWAIT;
          endcase
        end
        ST_FNEXT: begin
          if (tap_done) begin
            stb.mul_mode = 1'b1; stb.subtract = 1'b1;
            nxt = ST_SUBT;
          end else begin
            stb.rot_x = 1'b1; stb.rot_w = 1'b1; stb.tap_ph_a = 1'b1;
            nxt = ST_TURN;
          end
        end
        ST_SUBT: begin
          stb.mul_mode = 1'b1; stb.subtract = 1'b1; stb.err_en = 1'b1;
          nxt = ST_ELATCH;
        end
        ST_ELATCH: nxt = ST_ALIGN_A;
        ST_ALIGN_A: begin
          stb.wgt_sel = 1'b1; stb.mul_load = 1'b1; stb.tap_clr = 1'b1;
          stb.cyc_clr = 1'b1; stb.clr_acc = 1'b1;
          nxt = ST_USTART;
        end
        ST_USTART: begin
          stb.rot_x = 1'b1; stb.rot_w = 1'b1; stb.upd_sel = 1'b1;
          stb.mul_mode = 1'b1; stb.tap_ph_a = 1'b1;
          nxt = ST_UACC;
        end
        ST_UACC: begin
          stb.upd_sel = 1'b1; stb.mul_mode = 1'b1;
          stb.tap_ph_b = 1'b1; stb.acc_en = 1'b1;
          nxt = ST_UARM;
        end
        ST_UARM: begin
          stb.upd_sel = 1'b1;
          nxt = ST_UWAIT;
        end
        ST_UWAIT: begin
          stb.upd_sel = 1'b1;
          case (flg)
            2'b10: begin
              stb.wgt_sel = 1'b1; stb.st_weight = 1'b1;
              stb.mul_load = 1'b1; stb.cyc_clr = 1'b1;
              nxt = ST_UNEXT;
            end
            2'b11: begin
              stb.st_weight = 1'b1; stb.rot_x = 1'b1;
              nxt = ST_UNEXT;
            end
            default: nxt = ST_UWAIT;
          endcase
        end
        ST_UNEXT: begin
          if (tap_done) nxt = ST_ALIGN_B;
          else begin
            stb.clr_acc = 1'b1;
            nxt = ST_USTART;
          end
        end
        ST_ALIGN_B: begin
          stb.clr_all = 1'b1; stb.clr_acc = 1'b1;
          nxt = ST_START;
        end
        default: nxt = ST_START;
      endcase
    end
  end
endmodule

// File: rtl/lms_seq_ctrl.sv
module lms_seq_ctrl
  import lms_seq_pkg::*;
#(
  parameter int TAPS       = 8,
  parameter int MUL_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ld_sample,
  output logic st_weight,
  output logic rot_x,
  output logic rot_w,
  output logic upd_sel,
  output logic wgt_sel,
  output logic mul_mode,
  output logic mul_load,
  output logic tap_clr,
  output logic cyc_clr,
  output logic tap_ph_a,
  output logic tap_ph_b,
  output logic subtract,
  output logic acc_en,
  output logic err_en,
  output logic clr_all,
  output logic clr_acc
);
  strobe_t stb;
  logic    cyc_done;
  logic    tap_done;

  lms_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .cyc_done (cyc_done),
    .tap_done (tap_done),
    .stb      (stb)
  );

  lms_step_counter #(.LIMIT(MUL_CYCLES)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stb.cyc_clr | stb.clr_all),
    .en    (1'b1),
    .done  (cyc_done)
  );

  lms_step_counter #(.LIMIT(TAPS)) u_tap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stb.tap_clr | stb.clr_all),
    .en    (stb.tap_ph_b),
    .done  (tap_done)
  );

  assign ld_sample = stb.ld_sample;
  assign st_weight = stb.st_weight;
  assign rot_x     = stb.rot_x;
  assign rot_w     = stb.rot_w;
  assign upd_sel   = stb.upd_sel;
  assign wgt_sel   = stb.wgt_sel;
  assign mul_mode  = stb.mul_mode;
  assign mul_load  = stb.mul_load;
  assign tap_clr   = stb.tap_clr;
  assign cyc_clr   = stb.cyc_clr;
  assign tap_ph_a  = stb.tap_ph_a;
  assign tap_ph_b  = stb.tap_ph_b;
  assign subtract  = stb.subtract;
  assign acc_en    = stb.acc_en;
  assign err_en    = stb.err_en;
  assign clr_all   = stb.clr_all;
  assign clr_acc   = stb.clr_acc;
endmodule

// File: rtl/lms_seq_ctrl_chk.sv
module lms_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic ld_sample,
  input logic st_weight,
  input logic upd_sel,
  input logic mul_load,
  input logic tap_clr,
  input logic cyc_clr,
  input logic tap_ph_a,
  input logic tap_ph_b,
  input logic subtract,
  input logic acc_en,
  input logic err_en,
  input logic clr_all,
  input logic clr_acc,
  input logic cyc_done,
  input logic tap_done
);
  a_r2_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (clr_all && clr_acc && !acc_en && !mul_load && !st_weight));

  a_r2_restart_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restart) |-> ld_sample);

  a_r3_cyc_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !cyc_clr && !clr_all) |=> cyc_done);

  a_r3_tap_flag_waits_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!tap_done && !tap_ph_b && !tap_clr && !clr_all) |=> !tap_done);

  a_r4_reload_clears_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && mul_load) |-> cyc_clr);

  a_r5_err_after_subtract: assert property (@(posedge clk) disable iff (!rst_n)
    err_en |-> (subtract && $past(subtract)));

  a_r7_store_on_update_path: assert property (@(posedge clk) disable iff (!rst_n)
    st_weight |-> upd_sel);

  a_r8_clear_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !restart) |=> (ld_sample || restart));

  a_r10_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_ph_a && tap_ph_b));

  a_r10_b_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
    tap_ph_b |-> $past(tap_ph_a));
endmodule

bind lms_seq_ctrl lms_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .ld_sample (ld_sample),
  .st_weight (st_weight),
  .upd_sel   (upd_sel),
  .mul_load  (mul_load),
  .tap_clr   (tap_clr),
  .cyc_clr   (cyc_clr),
  .tap_ph_a  (tap_ph_a),
  .tap_ph_b  (tap_ph_b),
  .subtract  (subtract),
  .acc_en    (acc_en),
  .err_en    (err_en),
  .clr_all   (clr_all),
  .clr_acc   (clr_acc),
  .cyc_done  (cyc_done),
  .tap_done  (tap_done)
);

// File: tb/sim_lms_seq_ctrl.sv
`timescale 1ns/1ps
module sim_lms_seq_ctrl;
  localparam int B_LD = 16, B_SW = 15, B_RX = 14, B_RW = 13, B_US = 12;
  localparam int B_WS = 11, B_MM = 10, B_ML = 9, B_TC = 8, B_CC = 7;
  localparam int B_TA = 6, B_TB = 5, B_SU = 4, B_AC = 3, B_ER = 2;
  localparam int B_CA = 1, B_CK = 0;
  localparam int ITER = 151;

  localparam logic [16:0] P_START = 17'((1<<B_LD)|(1<<B_ML)|(1<<B_TC)|(1<<B_CC));
  localparam logic [16:0] P_FETCH = 17'((1<<B_RX)|(1<<B_RW)|(1<<B_TA));
  localparam logic [16:0] P_TURN  = 17'(1<<B_TB);
  localparam logic [16:0] P_W10   = 17'((1<<B_ML)|(1<<B_AC)|(1<<B_CC));
  localparam logic [16:0] P_W11   = 17'(1<<B_AC);
  localparam logic [16:0] P_SUB1  = 17'((1<<B_MM)|(1<<B_SU));
  localparam logic [16:0] P_SUB2  = 17'((1<<B_MM)|(1<<B_SU)|(1<<B_ER));
  localparam logic [16:0] P_ALIGN = 17'((1<<B_WS)|(1<<B_ML)|(1<<B_TC)|(1<<B_CC)|(1<<B_CK));
  localparam logic [16:0] P_U10   = 17'((1<<B_US)|(1<<B_WS)|(1<<B_SW)|(1<<B_ML)|(1<<B_CC));
  localparam logic [16:0] P_U11   = 17'((1<<B_US)|(1<<B_SW)|(1<<B_RX));
  localparam logic [16:0] P_CLEAR = 17'((1<<B_CA)|(1<<B_CK));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic ld_sample, st_weight, rot_x, rot_w, upd_sel, wgt_sel, mul_mode, mul_load;
  logic tap_clr, cyc_clr, tap_ph_a, tap_ph_b, subtract, acc_en, err_en, clr_all, clr_acc;
  logic [16:0] obs;
  logic [16:0] vec [0:ITER];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lms_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .ld_sample(ld_sample), .st_weight(st_weight), .rot_x(rot_x), .rot_w(rot_w),
    .upd_sel(upd_sel), .wgt_sel(wgt_sel), .mul_mode(mul_mode), .mul_load(mul_load),
    .tap_clr(tap_clr), .cyc_clr(cyc_clr), .tap_ph_a(tap_ph_a), .tap_ph_b(tap_ph_b),
    .subtract(subtract), .acc_en(acc_en), .err_en(err_en), .clr_all(clr_all),
    .clr_acc(clr_acc)
  );

  assign obs = {ld_sample, st_weight, rot_x, rot_w, upd_sel, wgt_sel, mul_mode,
                mul_load, tap_clr, cyc_clr, tap_ph_a, tap_ph_b, subtract, acc_en,
                err_en, clr_all, clr_acc};

  function automatic int exp_count(input int b);
    case (b)
      B_LD: return 1;   B_SW: return 8;   B_RX: return 17;  B_RW: return 16;
      B_US: return 65;  B_WS: return 8;   B_MM: return 18;  B_ML: return 16;
      B_TC: return 2;   B_CC: return 16;  B_TA: return 16;  B_TB: return 16;
      B_SU: return 2;   B_AC: return 16;  B_ER: return 1;   B_CA: return 1;
      default: return 9;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [16:0] got,
                     input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    restart = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // Records one iteration starting at the current (start-state) cycle and checks it.
  task automatic run_iteration(input string tag);
    int zero_bad;
    for (int c = 0; c <= ITER; c++) begin
      vec[c] = obs;
      if (c < ITER) tick();
    end
    chk("R1", {tag, " start state"}, vec[0], P_START);
    chk("R1", {tag, " first rotate"}, vec[1], P_FETCH);
    chk("R3", {tag, " first tap step"}, vec[2], P_TURN);
    zero_bad = 0;
    for (int c = 3; c <= 8; c++) if (vec[c] != '0) zero_bad++;
    chk_int("R4", {tag, " quiet filter wait cycles 3..8"}, zero_bad, 0);
    chk("R3", {tag, " first multiply done at cycle 9"}, vec[9], P_W10);
    chk("R3", {tag, " seventh tap continues loop"}, vec[64], P_FETCH);
    chk("R4", {tag, " last filter completion"}, vec[72], P_W11);
    chk("R5", {tag, " subtract first cycle"}, vec[73], P_SUB1);
    chk("R5", {tag, " subtract with error latch"}, vec[74], P_SUB2);
    chk("R6", {tag, " alignment idle"}, vec[75], '0);
    chk("R6", {tag, " update setup"}, vec[76], P_ALIGN);
    chk("R7", {tag, " first weight store"}, vec[85], P_U10);
    chk("R7", {tag, " final weight store"}, vec[148], P_U11);
    chk("R8", {tag, " trailing idle"}, vec[149], '0);
    chk("R8", {tag, " closing clear"}, vec[150], P_CLEAR);
    chk("R8", {tag, " next iteration start"}, vec[151], P_START);
    for (int b = 0; b < 17; b++) begin
      int n;
      n = 0;
      for (int c = 0; c < ITER; c++) n += int'(vec[c][b]);
      chk_int("R9", $sformatf("%s strobe bit %0d count", tag, b), n, exp_count(b));
    end
  endtask

  task automatic test_reset_and_iteration();
    do_reset();
    chk("R1", "state after reset", obs, P_START);
    run_iteration("base");
  endtask

  task automatic test_restart_in_filter_wait();
    do_reset();
    repeat (9) tick();
    restart = 1'b1;
    #1;
    chk("R2", "restart beats filter completion", obs, P_CLEAR);
    tick();
    restart = 1'b0;
    #1;
    run_iteration("after filter restart");
  endtask

  task automatic test_restart_at_weight_store();
    do_reset();
    repeat (85) tick();
    restart = 1'b1;
    #1;
    chk("R2", "restart beats weight store", obs, P_CLEAR);
    tick();
    restart = 1'b0;
    #1;
    run_iteration("after update restart");
  endtask

  task automatic test_restart_held();
    do_reset();
    repeat (5) tick();
    restart = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R2", $sformatf("held restart cycle %0d", i), obs, P_CLEAR);
      tick();
    end
    restart = 1'b0;
    #1;
    run_iteration("after held restart");
  endtask

  initial begin
    test_reset_and_iteration();
    test_restart_in_filter_wait();
    test_restart_at_weight_store();
    test_restart_held();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule